// File: doc/BRIEF.md
# Pipelined-Address Bus Cycle Sequencer

This block sequences bus cycles on a 32-bit processor local bus. It accepts one pending internal request at a time, made of an address, a cycle kind and a valid flag. For each request it places the address and kind on the bus and marks them with a one-clock strobe. The cycle then stays in a data phase until the external ready input is sampled high. The external bus-size input can ask for a cycle to be split into two 16-bit halves.

An external next-address input lets the following cycle's address overlap the current data phase. When that input is accepted, the next request's address goes out early and its cycle starts directly in the data phase. Look-ahead is limited to one cycle. The first cycle after the bus has been idle is never overlapped. Once next-address has been accepted, the current cycle counts as full width, so a 16-bit split request no longer takes effect for it.

Top module: `pipe_bus_seq`

## Requirements
- R1: While reset is low at a clock edge, and after that edge, the phase output is 0 (idle), the strobe is low, the address, kind and upper-half outputs are zero, and req_ack is low.
- R2: A valid request seen in idle is acknowledged in that same clock (req_ack high together with req_valid). At the following edge the phase becomes 1 (address state), with the strobe high and the request's address and kind on the bus. One clock later the phase is 2 (data state).
- R3: In the first data state of a cycle that began with an address state, a high next-address input is ignored. From a wait state (a repeated data state) of such a cycle, it is accepted.
- R4: When next-address is accepted and a request is pending, the next phase is 3 (pipelined, next address out). The request is acknowledged, and the strobe pulses with the new address while the current cycle keeps waiting for ready.
- R5: When next-address is accepted with no request pending, the next phase is 4 (pipelined, nothing queued). A request that arrives while ready is still low moves the sequencer to phase 3, with a strobe and the new address.
- R6: A cycle ends only when ready is sampled high, after any number of wait states. Ready in phase 3 starts the early-issued cycle in phase 2, with no new strobe.
- R7: The strobe is never high on two consecutive clocks, and the address output keeps its value on the clock after every strobe.
- R8: Ready with the 16-bit size input high, in a cycle without accepted next-address, repeats the same address through phase 1 with upper-half high and no acknowledge. The repeated half is not split again.
- R9: Ready with the 16-bit size input high in phase 3 or 4 causes no split.
- R10: A cycle that started in the data phase through pipelining may accept next-address in its first data state.
- R11: When ready and next-address are both high in a data state, ready wins. The cycle ends, and a pending request starts in phase 1, not phase 3.
- R12: Ready in phase 4 moves to phase 1 if a request is pending, and to idle otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Internal request pending |
| req_addr | input | ADDR_W | Address of the pending request |
| req_kind | input | KIND_W | Cycle kind of the pending request |
| req_ack | output | 1 | Request taken in this clock |
| bus_ready | input | 1 | Current cycle completes at this edge |
| bus_next | input | 1 | External request to issue the next address early |
| bus_size16 | input | 1 | Current cycle is on a 16-bit device |
| bus_addr | output | ADDR_W | Address driven on the bus |
| bus_kind | output | KIND_W | Cycle kind driven on the bus |
| bus_upper | output | 1 | Address refers to the upper 16-bit half |
| bus_strobe | output | 1 | One-clock mark of a new address |
| bus_phase | output | 3 | Sequencer phase: 0 idle, 1 address, 2 data, 3 pipelined with address, 4 pipelined idle |

## Verification
The assertions check on every clock that strobes are spaced apart and that the address holds after each one. They also check that a cycle's first data state never leads straight into a pipelined phase, that ready in a pipelined phase never starts a split half, and that no data phase falls to idle without ready. Only the directed scenarios can show the full sequences. These are the pending and not-pending next-address paths, the exact phase after each ready, the repeat of a split address with no acknowledge, and the rule that ready beats next-address when both arrive together.

// File: rtl/pbs_pkg.sv
// Shared types for the pipelined-address bus sequencer.
package pbs_pkg;
    typedef enum logic [2:0] {
        PH_IDLE      = 3'd0,
        PH_ADDR      = 3'd1,
        PH_DATA      = 3'd2,
        PH_PIPE_ADDR = 3'd3,
        PH_PIPE_WAIT = 3'd4
    } bus_phase_t;
endpackage

// File: rtl/pbs_fsm.sv
// Phase sequencer. Decides when a request is taken, when a 16-bit
// split half is started and when next-address is honoured.
// Assumes one pending request, held on req_valid until taken.
module pbs_fsm
    import pbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       ready,
    input  logic       next_req,
    input  logic       size16,
    output bus_phase_t phase,
    output logic       take_new,
    output logic       take_split
);
    bus_phase_t st, nxt;
    logic waited;      // current cycle is in a wait state
    logic pipe_start;  // current cycle began in the data phase
    logic upper;       // current cycle is the second split half
    logic na_ok;

    assign na_ok = pipe_start | waited;
    assign phase = st;

    // Next-phase and take decisions.
    always_comb begin
        nxt        = st;
        take_new   = 1'b0;
        take_split = 1'b0;
        case (st)
            PH_IDLE: begin
                if (req_valid) begin
                    take_new = 1'b1;
                    nxt      = PH_ADDR;
                end
            end
            PH_ADDR: nxt = PH_DATA;
            PH_DATA: begin
                if (ready) begin
                    if (size16 && !upper) begin
                        take_split = 1'b1;
                        nxt        = PH_ADDR;
                    end else if (req_valid) begin
                        take_new = 1'b1;
                        nxt      = PH_ADDR;
                    end else begin
                        nxt = PH_IDLE;
                    end
                end else if (next_req && na_ok) begin
                    if (req_valid) begin
                        take_new = 1'b1;
                        nxt      = PH_PIPE_ADDR;
                    end else begin
                        nxt = PH_PIPE_WAIT;
                    end
                end
            end
            PH_PIPE_ADDR: begin
                if (ready) nxt = PH_DATA;
            end
            PH_PIPE_WAIT: begin
                if (ready) begin
                    if (req_valid) begin
                        take_new = 1'b1;
                        nxt      = PH_ADDR;
                    end else begin
                        nxt = PH_IDLE;
                    end
                end else if (req_valid) begin
                    take_new = 1'b1;
                    nxt      = PH_PIPE_ADDR;
                end
            end
            default: nxt = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= PH_IDLE;
        else        st <= nxt;
    end

    // Per-cycle flags: wait state seen, pipelined start, split half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            waited     <= 1'b0;
            pipe_start <= 1'b0;
            upper      <= 1'b0;
        end else begin
            if (st == PH_DATA && nxt == PH_DATA) waited <= 1'b1;
            else if (nxt != PH_DATA)             waited <= 1'b0;

            if (st == PH_PIPE_ADDR && nxt == PH_DATA) pipe_start <= 1'b1;
            else if (nxt == PH_ADDR)                  pipe_start <= 1'b0;

            if (take_split) upper <= 1'b1;
            else if ((take_new && nxt == PH_ADDR) ||
                     (st == PH_PIPE_ADDR && nxt == PH_DATA)) upper <= 1'b0;
        end
    end

    AST_FIRST_DATA_NO_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PH_DATA && !pipe_start && !waited)
        |=> (st != PH_PIPE_ADDR && st != PH_PIPE_WAIT)); // R3
    AST_NO_SPLIT_AFTER_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == PH_PIPE_ADDR || st == PH_PIPE_WAIT) && ready)
        |=> !(st == PH_ADDR && upper)); // R9
    AST_WAIT_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == PH_DATA || st == PH_PIPE_ADDR || st == PH_PIPE_WAIT) && !ready)
        |=> (st != PH_IDLE && st != PH_ADDR)); // R6
endmodule

// File: rtl/pbs_outreg.sv
// Bus output register: address, kind, upper-half flag and strobe.
// Assumes load_new and load_split are never high together.
module pbs_outreg #(
    parameter int ADDR_W = 32,
    parameter int KIND_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_new,
    input  logic              load_split,
    input  logic [ADDR_W-1:0] new_addr,
    input  logic [KIND_W-1:0] new_kind,
    output logic [ADDR_W-1:0] addr,
    output logic [KIND_W-1:0] kind,
    output logic              upper,
    output logic              strobe
);
    // Capture a new address, or mark the upper half of a split.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr   <= '0;
            kind   <= '0;
            upper  <= 1'b0;
            strobe <= 1'b0;
        end else begin
            strobe <= load_new | load_split;
            if (load_new) begin
                addr  <= new_addr;
                kind  <= new_kind;
                upper <= 1'b0;
            end else if (load_split) begin
                upper <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pipe_bus_seq.sv
// Top of the pipelined-address bus sequencer. Joins the phase
// sequencer to the bus output register. Assumes inputs are
// synchronous to clk.
module pipe_bus_seq #(
    parameter int ADDR_W = 32,
    parameter int KIND_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [KIND_W-1:0] req_kind,
    output logic              req_ack,
    input  logic              bus_ready,
    input  logic              bus_next,
    input  logic              bus_size16,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [KIND_W-1:0] bus_kind,
    output logic              bus_upper,
    output logic              bus_strobe,
    output logic [2:0]        bus_phase
);
    import pbs_pkg::*;

    bus_phase_t ph;
    logic take_new, take_split;

    pbs_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .ready     (bus_ready),
        .next_req  (bus_next),
        .size16    (bus_size16),
        .phase     (ph),
        .take_new  (take_new),
        .take_split(take_split)
    );

    pbs_outreg #(.ADDR_W(ADDR_W), .KIND_W(KIND_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_new  (take_new),
        .load_split(take_split),
        .new_addr  (req_addr),
        .new_kind  (req_kind),
        .addr      (bus_addr),
        .kind      (bus_kind),
        .upper     (bus_upper),
        .strobe    (bus_strobe)
    );

    assign req_ack   = take_new & rst_n;
    assign bus_phase = ph;

    AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        bus_strobe |=> !bus_strobe); // R7
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_strobe |=> $stable(bus_addr)); // R7
    AST_ACK_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> req_valid); // R2
endmodule

// File: tb/test_pipe_bus_seq.sv
module test_pipe_bus_seq;
    localparam int AW = 32;
    localparam int KW = 3;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic [AW-1:0] req_addr;
    logic [KW-1:0] req_kind;
    logic          req_ack;
    logic          bus_ready, bus_next, bus_size16;
    logic [AW-1:0] bus_addr;
    logic [KW-1:0] bus_kind;
    logic          bus_upper, bus_strobe;
    logic [2:0]    bus_phase;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pipe_bus_seq #(.ADDR_W(AW), .KIND_W(KW)) i_pipe_bus_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_addr(req_addr), .req_kind(req_kind),
        .req_ack(req_ack), .bus_ready(bus_ready), .bus_next(bus_next),
        .bus_size16(bus_size16), .bus_addr(bus_addr), .bus_kind(bus_kind),
        .bus_upper(bus_upper), .bus_strobe(bus_strobe), .bus_phase(bus_phase)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(input logic v, input logic [AW-1:0] a, input logic rdy,
                         input logic na, input logic s16);
        req_valid = v; req_addr = a; req_kind = a[2:0];
        bus_ready = rdy; bus_next = na; bus_size16 = s16;
        #1;
    endtask

    task automatic idle_inputs();
        drive(1'b0, '0, 1'b0, 1'b0, 1'b0);
    endtask

    // Phase, strobe and address after an edge.
    task automatic expect_bus(input string tag, input logic [2:0] ph,
                              input logic stb, input logic [AW-1:0] a);
        chk({tag, " phase"},  bus_phase,  ph);
        chk({tag, " strobe"}, bus_strobe, stb);
        chk({tag, " addr"},   bus_addr,   a);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        drive(1'b1, 32'h55, 1'b1, 1'b1, 1'b1);
        tick(); tick();
        chk("R1 ack in reset", req_ack, 1'b0);
        expect_bus("R1 reset", 3'd0, 1'b0, '0);
        chk("R1 kind", bus_kind, '0);
        chk("R1 upper", bus_upper, 1'b0);
        idle_inputs();
        rst_n = 1'b1;
        tick();
        chk("R1 still idle", bus_phase, 3'd0);
    endtask

    task automatic test_basic();
        drive(1'b1, 32'h1000, 1'b0, 1'b0, 1'b0);
        chk("R2 ack", req_ack, 1'b1);
        tick();
        expect_bus("R2 addr state", 3'd1, 1'b1, 32'h1000);
        chk("R2 kind", bus_kind, 3'h0);
        drive(1'b0, '0, 1'b0, 1'b0, 1'b0);
        tick();
        expect_bus("R2 data state", 3'd2, 1'b0, 32'h1000);
        drive(1'b0, '0, 1'b0, 1'b1, 1'b0);
        tick();
        chk("R3 next ignored in first data", bus_phase, 3'd2);
        drive(1'b0, '0, 1'b0, 1'b0, 1'b0);
        tick(); tick();
        chk("R6 waits without ready", bus_phase, 3'd2);
        drive(1'b0, '0, 1'b1, 1'b0, 1'b0);
        tick();
        expect_bus("R6 ends on ready", 3'd0, 1'b0, 32'h1000);
        idle_inputs();
    endtask

    task automatic test_pipe_pending();
        drive(1'b1, 32'h2000, 1'b0, 1'b0, 1'b0);
        tick(); idle_inputs();
        tick(); tick();
        chk("R3 wait state", bus_phase, 3'd2);
        drive(1'b1, 32'h2004, 1'b0, 1'b1, 1'b0);
        chk("R4 ack", req_ack, 1'b1);
        tick();
        expect_bus("R4 pipelined addr", 3'd3, 1'b1, 32'h2004);
        idle_inputs();
        tick();
        expect_bus("R7 addr held", 3'd3, 1'b0, 32'h2004);
        drive(1'b0, '0, 1'b1, 1'b0, 1'b0);
        tick();
        expect_bus("R6 early cycle in data", 3'd2, 1'b0, 32'h2004);
        drive(1'b1, 32'h2008, 1'b0, 1'b1, 1'b0);
        tick();
        expect_bus("R10 next in first data", 3'd3, 1'b1, 32'h2008);
        drive(1'b0, '0, 1'b1, 1'b0, 1'b0);
        tick();
        chk("R6 pipelined data", bus_phase, 3'd2);
        tick();
        chk("R6 back to idle", bus_phase, 3'd0);
        idle_inputs();
    endtask

    task automatic test_pipe_empty();
        drive(1'b1, 32'h3000, 1'b0, 1'b0, 1'b0);
        tick(); idle_inputs(); tick(); tick();
        drive(1'b0, '0, 1'b0, 1'b1, 1'b0);
        tick();
        expect_bus("R5 pipelined idle", 3'd4, 1'b0, 32'h3000);
        idle_inputs();
        tick();
        chk("R5 stays", bus_phase, 3'd4);
        drive(1'b1, 32'h3010, 1'b0, 1'b0, 1'b0);
        tick();
        expect_bus("R5 late request", 3'd3, 1'b1, 32'h3010);
        drive(1'b0, '0, 1'b1, 1'b0, 1'b1);
        tick();
        expect_bus("R9 size ignored", 3'd2, 1'b0, 32'h3010);
        chk("R9 upper", bus_upper, 1'b0);
        drive(1'b0, '0, 1'b1, 1'b0, 1'b0);
        tick();
        chk("R9 idle", bus_phase, 3'd0);
        // Ready in pipelined idle with a pending request.
        drive(1'b1, 32'h3100, 1'b0, 1'b0, 1'b0);
        tick(); idle_inputs(); tick(); tick();
        drive(1'b0, '0, 1'b0, 1'b1, 1'b0);
        tick();
        chk("R12 in phase 4", bus_phase, 3'd4);
        drive(1'b1, 32'h3104, 1'b1, 1'b0, 1'b1);
        tick();
        expect_bus("R12 to address state", 3'd1, 1'b1, 32'h3104);
        chk("R12 R9 no upper", bus_upper, 1'b0);
        drive(1'b0, '0, 1'b0, 1'b0, 1'b0);
        tick();
        drive(1'b0, '0, 1'b1, 1'b0, 1'b0);
        tick();
        chk("R12 idle", bus_phase, 3'd0);
        idle_inputs();
    endtask

    task automatic test_split();
        drive(1'b1, 32'h4000, 1'b0, 1'b0, 1'b0);
        tick(); idle_inputs(); tick();
        drive(1'b1, 32'h4100, 1'b1, 1'b0, 1'b1);
        chk("R8 no ack on split", req_ack, 1'b0);
        tick();
        expect_bus("R8 repeat addr", 3'd1, 1'b1, 32'h4000);
        chk("R8 upper", bus_upper, 1'b1);
        drive(1'b1, 32'h4100, 1'b0, 1'b0, 1'b0);
        tick();
        drive(1'b1, 32'h4100, 1'b1, 1'b0, 1'b1);
        chk("R8 ack after second half", req_ack, 1'b1);
        tick();
        expect_bus("R8 no second split", 3'd1, 1'b1, 32'h4100);
        chk("R8 upper cleared", bus_upper, 1'b0);
        idle_inputs();
        tick();
        drive(1'b0, '0, 1'b1, 1'b0, 1'b0);
        tick();
        chk("R8 idle", bus_phase, 3'd0);
        idle_inputs();
    endtask

    task automatic test_ready_wins();
        drive(1'b1, 32'h5000, 1'b0, 1'b0, 1'b0);
        tick(); idle_inputs(); tick(); tick();
        drive(1'b1, 32'h5004, 1'b1, 1'b1, 1'b0);
        tick();
        expect_bus("R11 ready wins", 3'd1, 1'b1, 32'h5004);
        idle_inputs();
        tick();
        drive(1'b0, '0, 1'b1, 1'b0, 1'b0);
        tick();
        chk("R11 idle", bus_phase, 3'd0);
        idle_inputs();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        idle_inputs();
        #2;
        test_reset();
        test_basic();
        test_pipe_pending();
        test_pipe_empty();
        test_split();
        test_ready_wins();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule